// File: doc/BRIEF.md
# Program-to-Data Window Bridge

This block lets the upper half of a 16-bit data address space read constant tables held in a 24-bit-wide program memory. A data-side read whose effective address has bit 15 set is translated when the window is enabled, no table operation is running and the operand is on the X side. An 8-bit page value supplies the high program-address bits and address bits 14:0 supply the rest. The block drives a program-memory read port, keeps the low 16 bits of the fetched word, and returns them as read data. Every other request is steered to ordinary data RAM through a select output.

A windowed access may cost extra cycles. The block holds a stall output high for each of those cycles. When the core is outside a repeat loop, every windowed access pays the penalty. Inside a repeat loop, the penalty applies only on the boundary iterations signalled by the loop status flags. Page, enable and address are captured when a request is accepted, so the core may change them during an access without affecting it.

Top module: `prog_window_bridge`

## Requirements
- R1: A request is windowed only when reqAddr[15]=1, winEnable=1, tableBusy=0 and reqYSpace=0. A windowed request starts a program read on the next cycle. Any other request raises ramSel in the same cycle and starts no program read and no stall.
- R2: During a windowed access, pmAddr equals {pageReg, reqAddr[14:0]} as captured at acceptance, and pmRdEn stays high through the whole access.
- R3: A word read (reqByte=0) returns pmRdData[15:0]. Bits 23:16 of the fetched word never reach rdData.
- R4: A byte read (reqByte=1) returns fetched bits 15:8 when reqAddr[0]=1 and bits 7:0 when reqAddr[0]=0. The byte is placed in rdData[7:0] and rdData[15:8] is zero.
- R5: With rptActive=0, a windowed access holds stall high for exactly PENALTY_CYC (default 1) cycles, starting the cycle after acceptance.
- R6: With rptActive=1, the penalty applies if any of rptFirst, rptLast, rptIntExit or rptReentry is 1. If none of them is set, the access completes with no stall.
- R7: rdValid is high for exactly one cycle: the first access cycle with stall low. That is one cycle after acceptance with no penalty, and PENALTY_CYC+1 cycles after acceptance with a penalty.
- R8: Changes to pageReg or winEnable after acceptance do not alter pmAddr or rdData of the access in flight.
- R9: While tableBusy=1, a request with reqAddr[15]=1 and winEnable=1 is routed to RAM.
- R10: A request flagged reqYSpace=1 is never served through the window, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Data read request this cycle |
| reqAddr | input | 16 | Data effective address |
| reqByte | input | 1 | 1 = byte read, 0 = word read |
| reqYSpace | input | 1 | Operand belongs to the Y data space |
| winEnable | input | 1 | Window enable control bit |
| pageReg | input | 8 | Program page for the window |
| tableBusy | input | 1 | Table read/write in progress |
| rptActive | input | 1 | Core is inside a repeat loop |
| rptFirst | input | 1 | First loop iteration |
| rptLast | input | 1 | Last loop iteration |
| rptIntExit | input | 1 | Iteration before leaving for an interrupt |
| rptReentry | input | 1 | Iteration re-entering after an interrupt |
| pmRdEn | output | 1 | Program-memory read enable |
| pmAddr | output | 23 | Program-memory address |
| pmRdData | input | 24 | Program-memory read word (same-cycle) |
| ramSel | output | 1 | Request is routed to data RAM |
| stall | output | 1 | Extra cycle in progress |
| rdValid | output | 1 | rdData is valid |
| rdData | output | 16 | Returned read data |

## Verification
On every cycle, assertions check that a stall is always followed by another stall or by the data-valid cycle, that valid never lasts two cycles, and that RAM routing never overlaps a program read. They also check that a table operation blocks a new window access, that the captured address stays frozen across a multi-cycle access, and that byte results are zero-extended. The exact penalty choice across the five repeat-loop cases, the address translation over a sweep of pages and offsets, the byte-lane selection, and the insensitivity to page and enable changes during an access show only in the bench scenarios. Those scenarios compare the results against arithmetic expectations.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // accept a windowed request this cycle
    logic fetch;    // access in flight (program read active)
    logic done;     // data-valid cycle
  } pwb_strobe_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int PENALTY_CYC = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        winHit,
  input  logic        rptActive,
  input  logic        rptFirst,
  input  logic        rptLast,
  input  logic        rptIntExit,
  input  logic        rptReentry,
  output pwb_strobe_t strb,
  output logic        busy,
  output logic        stall
);
  localparam int CNT_W = (PENALTY_CYC < 1) ? 1 : $clog2(PENALTY_CYC + 1);

  logic             busyQ;
  logic [CNT_W-1:0] penLeftQ;
  logic             penNeeded;

  // Boundary iterations of a repeat loop keep the penalty
  assign penNeeded = !rptActive || rptFirst || rptLast || rptIntExit || rptReentry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      penLeftQ <= '0;
    end else if (!busyQ) begin
      if (winHit) begin
        busyQ    <= 1'b1;
        penLeftQ <= penNeeded ? CNT_W'(PENALTY_CYC) : '0;
      end
    end else if (penLeftQ == '0) begin
      busyQ <= 1'b0;
    end else begin
      penLeftQ <= penLeftQ - 1'b1;
    end
  end

  assign busy         = busyQ;
  assign stall        = busyQ && (penLeftQ != '0);
  assign strb.capture = winHit && !busyQ;
  assign strb.fetch   = busyQ;
  assign strb.done    = busyQ && (penLeftQ == '0);

  // R7: a stall is followed by another stall or by the valid cycle
  p_stall_then_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (stall || strb.done));
  // R7: valid lasts a single cycle
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done);
  // R5: a stall only happens inside an access that began with a capture
  p_stall_after_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(strb.capture));
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 15,
  parameter int DATA_W = 16,
  parameter int PM_W   = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pwb_strobe_t             strb,
  input  logic [OFF_W:0]          reqAddr,
  input  logic                    reqByte,
  input  logic [PAGE_W-1:0]       pageReg,
  input  logic [PM_W-1:0]         pmRdData,
  output logic [PAGE_W+OFF_W-1:0] pmAddr,
  output logic [DATA_W-1:0]       rdData
);
  localparam int PA_W   = PAGE_W + OFF_W;
  localparam int BYTE_W = DATA_W / 2;

  logic [PA_W-1:0] addrQ;
  logic            byteQ;
  logic            hiLaneQ;
  logic [DATA_W-1:0] lowWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      byteQ   <= 1'b0;
      hiLaneQ <= 1'b0;
    end else if (strb.capture) begin
      addrQ   <= {pageReg, reqAddr[OFF_W-1:0]};
      byteQ   <= reqByte;
      hiLaneQ <= reqAddr[0];
    end
  end

  assign pmAddr  = addrQ;
  // Upper program-word bits are dropped
  assign lowWord = pmRdData[DATA_W-1:0];

  always_comb begin
    if (!byteQ)       rdData = lowWord;
    else if (hiLaneQ) rdData = {{BYTE_W{1'b0}}, lowWord[DATA_W-1:BYTE_W]};
    else              rdData = {{BYTE_W{1'b0}}, lowWord[BYTE_W-1:0]};
  end

  // R8: the captured address holds for the whole access
  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fetch && $past(strb.fetch)) |-> $stable(pmAddr));
  // R4: byte results are zero-extended
  p_byte_zext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && byteQ) |-> (rdData[DATA_W-1:BYTE_W] == '0));
endmodule

// File: rtl/prog_window_bridge.sv
module prog_window_bridge
  import pwb_pkg::*;
#(
  parameter int PAGE_W      = 8,
  parameter int OFF_W       = 15,
  parameter int DATA_W      = 16,
  parameter int PM_W        = 24,
  parameter int PENALTY_CYC = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [OFF_W:0]          reqAddr,
  input  logic                    reqByte,
  input  logic                    reqYSpace,
  input  logic                    winEnable,
  input  logic [PAGE_W-1:0]       pageReg,
  input  logic                    tableBusy,
  input  logic                    rptActive,
  input  logic                    rptFirst,
  input  logic                    rptLast,
  input  logic                    rptIntExit,
  input  logic                    rptReentry,
  output logic                    pmRdEn,
  output logic [PAGE_W+OFF_W-1:0] pmAddr,
  input  logic [PM_W-1:0]         pmRdData,
  output logic                    ramSel,
  output logic                    stall,
  output logic                    rdValid,
  output logic [DATA_W-1:0]       rdData
);
  pwb_strobe_t strb;
  logic        busy;
  logic        winHit;
  logic        inWindow;

  assign inWindow = reqAddr[OFF_W] && winEnable && !tableBusy && !reqYSpace;
  assign winHit   = reqValid && inWindow;

  pwb_ctrl #(.PENALTY_CYC(PENALTY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .winHit(winHit),
    .rptActive(rptActive), .rptFirst(rptFirst), .rptLast(rptLast),
    .rptIntExit(rptIntExit), .rptReentry(rptReentry),
    .strb(strb), .busy(busy), .stall(stall)
  );

  pwb_datapath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .PM_W(PM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqByte(reqByte),
    .pageReg(pageReg), .pmRdData(pmRdData), .pmAddr(pmAddr), .rdData(rdData)
  );

  assign pmRdEn  = strb.fetch;
  assign rdValid = strb.done;
  assign ramSel  = reqValid && !busy && !inWindow;

  // R1: RAM routing never overlaps a program read
  p_ram_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    pmRdEn |-> !ramSel);
  // R9: a table operation blocks a new window access
  p_table_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!pmRdEn && tableBusy) |=> !pmRdEn);
  // R10: a Y-space operand cannot open an access
  p_yspace_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!pmRdEn && reqYSpace) |=> !pmRdEn);
endmodule

// File: tb/prog_window_bridge_bench.sv
module prog_window_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        reqByte = 1'b0;
  logic        reqYSpace = 1'b0;
  logic        winEnable = 1'b0;
  logic [7:0]  pageReg = '0;
  logic        tableBusy = 1'b0;
  logic        rptActive = 1'b0, rptFirst = 1'b0, rptLast = 1'b0;
  logic        rptIntExit = 1'b0, rptReentry = 1'b0;
  logic        pmRdEn, ramSel, stall, rdValid;
  logic [22:0] pmAddr;
  logic [23:0] pmRdData;
  logic [15:0] rdData;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  function automatic logic [23:0] memWord(input logic [22:0] a);
    return {a[22:15] ^ 8'h3C, a[15:0] ^ 16'h5A96};
  endfunction
  assign pmRdData = memWord(pmAddr);

  prog_window_bridge u_prog_window_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqByte(reqByte),
    .reqYSpace(reqYSpace), .winEnable(winEnable), .pageReg(pageReg), .tableBusy(tableBusy),
    .rptActive(rptActive), .rptFirst(rptFirst), .rptLast(rptLast),
    .rptIntExit(rptIntExit), .rptReentry(rptReentry),
    .pmRdEn(pmRdEn), .pmAddr(pmAddr), .pmRdData(pmRdData), .ramSel(ramSel),
    .stall(stall), .rdValid(rdValid), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One windowed access; rpt = {active, first, last, intExit, reentry}
  task automatic runWin(input logic [15:0] ea, input logic isByte, input logic [4:0] rpt,
                        input logic [7:0] page, input logic disturb);
    logic [22:0] expAddr;
    logic [23:0] w;
    logic [15:0] expData;
    int expPen;
    int stalls;
    expPen  = (!rpt[4] || (rpt[3:0] != 4'b0)) ? 1 : 0;  // R5 / R6
    expAddr = {page, ea[14:0]};
    w       = memWord(expAddr);
    expData = !isByte ? w[15:0] : (ea[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]});
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ea; reqByte = isByte; pageReg = page; winEnable = 1'b1;
    {rptActive, rptFirst, rptLast, rptIntExit, rptReentry} = rpt;
    #1 check("R1 ramSel low on windowed request", 32'(ramSel), 0);
    @(negedge clk);
    reqValid = 1'b0;
    if (disturb) begin pageReg = ~page; winEnable = 1'b0; end
    stalls = 0;
    for (int g = 0; g < 8 && !rdValid; g++) begin
      check("R2 pmRdEn during stall", 32'(pmRdEn), 1);
      check("R2/R8 pmAddr during stall", 32'(pmAddr), 32'(expAddr));
      stalls++;
      @(negedge clk);
    end
    check(rpt[4] ? "R6 penalty cycles in loop" : "R5 penalty cycles", stalls, expPen);
    check("R7 rdValid reached, stall low", {31'b0, rdValid && !stall}, 1);
    check("R2/R8 pmAddr at valid", 32'(pmAddr), 32'(expAddr));
    check(isByte ? "R4 byte data" : "R3 word data", 32'(rdData), 32'(expData));
    @(negedge clk);
    check("R7 rdValid single cycle", 32'(rdValid), 0);
    check("R7 access ended", 32'(pmRdEn), 0);
    pageReg = page; winEnable = 1'b1;
  endtask

  // One request expected to go to RAM
  task automatic runRam(input string req, input logic [15:0] ea, input logic en,
                        input logic tbl, input logic ysp);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ea; winEnable = en; tableBusy = tbl; reqYSpace = ysp;
    #1 check({req, " ramSel"}, 32'(ramSel), 1);
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " no program read"}, 32'(pmRdEn), 0);
    check({req, " no stall"}, 32'(stall), 0);
    tableBusy = 1'b0; reqYSpace = 1'b0; winEnable = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset rdValid", 32'(rdValid), 0);
    check("R5 reset stall", 32'(stall), 0);
    check("R2 reset pmRdEn", 32'(pmRdEn), 0);
    rstN = 1'b1;

    // R5/R6: all repeat-loop cases, word and both byte lanes
    for (int c = 0; c < 6; c++) begin
      logic [4:0] r;
      case (c)
        0: r = 5'b00000;
        1: r = 5'b10000;
        2: r = 5'b11000;
        3: r = 5'b10100;
        4: r = 5'b10010;
        default: r = 5'b10001;
      endcase
      runWin(16'h8124, 1'b0, r, 8'h05, 1'b0);
      runWin(16'hA3C1, 1'b1, r, 8'h05, 1'b0);
      runWin(16'hA3C0, 1'b1, r, 8'h05, 1'b0);
    end

    // R2/R3: page and offset sweep
    for (int p = 0; p < 256; p += 37)
      for (int o = 0; o < 32768; o += 4099)
        runWin(16'h8000 | 16'(o & 32'h7FFE), 1'b0, 5'b10000, 8'(p), 1'b0);
    runWin(16'hFFFE, 1'b0, 5'b00000, 8'hFF, 1'b0);
    runWin(16'h8000, 1'b1, 5'b00000, 8'h00, 1'b0);

    // R8: page and enable changed mid-access
    runWin(16'h9876, 1'b0, 5'b00000, 8'h5A, 1'b1);
    runWin(16'hC001, 1'b1, 5'b10000, 8'hA7, 1'b1);

    // R1/R9/R10: routing to RAM
    runRam("R1 bit15 clear", 16'h7FFE, 1'b1, 1'b0, 1'b0);
    runRam("R1 window disabled", 16'h8002, 1'b0, 1'b0, 1'b0);
    runRam("R9 table busy", 16'h9000, 1'b1, 1'b1, 1'b0);
    runRam("R10 Y-space operand", 16'hB000, 1'b1, 1'b0, 1'b1);

    // Window usable again after the suppressed cases
    runWin(16'h9000, 1'b0, 5'b00000, 8'h11, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule